// File: doc/BRIEF.md
# Masked-Access GPIO Port

This block is an 8-pin general-purpose I/O port with a 32-bit register interface that decodes a 4 KB window. Software reaches the pin data through a window of 256 word addresses. Address bits [9:2] of each access act as a per-pin mask. One load can return any chosen subset of pins, and one store can change any chosen subset, with no read-modify-write.

A direction register sets each pin as output (1) or input (0). An output pin drives its stored data bit. An input pin drives a constant 1, so it floats high, and its data bit tracks the external level one clock later. Interrupt configuration and pad configuration registers are plain storage that software can read back. No edge or level detection feeds the raw interrupt status. The alternate-function select register is guarded. Only bits enabled in a commit register can change. The commit register itself accepts writes only after a key word has been written to the lock register. A block of identification bytes sits at the top of the window.

Reads are combinational from the address: `bus_rdata` is valid in the same cycle as `bus_addr`. A write takes effect at the rising clock edge on which `bus_we` is high.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register is 0x00 and every pin drives 1. The lock register reads 1 and the commit register reads 0xFF. The alternate-function select reads 0x00, `afsel_o` is 0x00 and `irq_o` is 0.
- R2: A read at any offset below 0x400 returns the 8-bit data register ANDed with offset bits [9:2], zero-extended to 32 bits.
- R3: A write at an offset below 0x400 changes only the data bits whose offset bit [2+i] and direction bit i are both 1. Every other data bit keeps its value.
- R4: Pin i drives data bit i when direction bit i is 1, and drives 1 when direction bit i is 0.
- R5: For a pin whose direction bit is 0, the data bit takes the value of `pin_i` one clock later. For a pin whose direction bit is 1, changes on `pin_i` have no effect on the data bit.
- R6: Writing exactly 0x0ACCE551 to offset 0x520 unlocks the port. Writing any other value there locks it. A read of 0x520 returns 1 while locked and 0 while unlocked.
- R7: A write to the commit register at offset 0x524 takes effect only while the port is unlocked.
- R8: A write to the alternate-function select at offset 0x420 changes only the bits whose commit bit is 1. `afsel_o` always equals that register.
- R9: The byte registers at 0x400, 0x404, 0x408, 0x40C, 0x410 and 0x500 to 0x51C store bits [7:0] of a write. They read back that byte with bits [31:8] zero.
- R10: Offsets 0xFD0 to 0xFFC return one identification byte per word, in this order: 0x00, 0x00, 0x00, 0x00, 0x61, 0x00, 0x18, 0x01, 0x0D, 0xF0, 0x05, 0xB1.
- R11: The raw status at 0x414 reads 0x00, because no detection source sets it. The masked status at 0x418 reads raw AND the mask register at 0x410. `irq_o` is the OR of the masked bits. A write to 0x41C clears raw bits where the written bit is 1.
- R12: Reads of unmapped offsets, and of the write-only clear at 0x41C, return 0. Writes to unmapped or read-only offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pin_i | input | 8 | External pin levels |
| pin_o | output | 8 | Pin drive values |
| afsel_o | output | 8 | Alternate-function select per pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Corrupted data state is visible on `pin_o` in the cycle after the write that should have set it. It is also visible on the next full-mask read, so the sweeps compare both after every masked store. An input bit that misses the sampling edge shows up one cycle after a `pin_i` change. A wrong lock or commit state shows only indirectly, through which bits of `afsel_o` move on the next guarded write. For that reason the sequence reads the lock and commit registers back before and after each alternate-function write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PIN_W  = 8;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;
    localparam int WORD_W = ADDR_W - 2;

    localparam int NUM_IRQ_CFG = 5;
    localparam int NUM_PAD     = 8;
    localparam int NUM_CFG     = NUM_IRQ_CFG + NUM_PAD;
    localparam int CFG_IDX_W   = $clog2(NUM_CFG);
    localparam int NUM_ID      = 12;
    localparam int ID_IDX_W    = $clog2(NUM_ID);

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    // Word addresses (byte offset >> 2)
    localparam logic [WORD_W-1:0] W_DATA_END = WORD_W'(1 << PIN_W);
    localparam logic [WORD_W-1:0] W_DIR      = 10'h100;
    localparam logic [WORD_W-1:0] W_IMASK    = 10'h104;
    localparam logic [WORD_W-1:0] W_RAW      = 10'h105;
    localparam logic [WORD_W-1:0] W_MASKED   = 10'h106;
    localparam logic [WORD_W-1:0] W_ICLR     = 10'h107;
    localparam logic [WORD_W-1:0] W_ALT      = 10'h108;
    localparam logic [WORD_W-1:0] W_PAD0     = 10'h140;
    localparam logic [WORD_W-1:0] W_LOCK     = 10'h148;
    localparam logic [WORD_W-1:0] W_COMMIT   = 10'h149;
    localparam logic [WORD_W-1:0] W_ID0      = 10'h3F4;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_CFG,
        SEL_RAW,
        SEL_MASKED,
        SEL_ICLR,
        SEL_ALT,
        SEL_LOCK,
        SEL_COMMIT,
        SEL_ID
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e               sel;
        logic [CFG_IDX_W-1:0]   cfg_idx;
        logic [ID_IDX_W-1:0]    id_idx;
        logic [PIN_W-1:0]       pin_mask;
    } decode_t;

    function automatic logic [PIN_W-1:0] id_byte(input logic [ID_IDX_W-1:0] idx);
        logic [PIN_W-1:0] b;
        case (idx)
            4'd4:    b = 8'h61;
            4'd6:    b = 8'h18;
            4'd7:    b = 8'h01;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    logic [WORD_W-1:0] word;
    logic [1:0]        unused_lane;

    assign word        = addr[ADDR_W-1:2];
    assign unused_lane = addr[1:0];

    always_comb begin
        dec          = '0;
        dec.sel      = SEL_NONE;
        dec.pin_mask = word[PIN_W-1:0];
        if (word < W_DATA_END) begin
            dec.sel = SEL_DATA;
        end else if (word >= W_DIR && word <= W_IMASK) begin
            dec.sel     = SEL_CFG;
            dec.cfg_idx = CFG_IDX_W'(word - W_DIR);
        end else if (word >= W_PAD0 && word < W_PAD0 + WORD_W'(NUM_PAD)) begin
            dec.sel     = SEL_CFG;
            dec.cfg_idx = CFG_IDX_W'(word - W_PAD0) + CFG_IDX_W'(NUM_IRQ_CFG);
        end else if (word >= W_ID0) begin
            dec.sel    = SEL_ID;
            dec.id_idx = ID_IDX_W'(word - W_ID0);
        end else begin
            case (word)
                W_RAW:    dec.sel = SEL_RAW;
                W_MASKED: dec.sel = SEL_MASKED;
                W_ICLR:   dec.sel = SEL_ICLR;
                W_ALT:    dec.sel = SEL_ALT;
                W_LOCK:   dec.sel = SEL_LOCK;
                W_COMMIT: dec.sel = SEL_COMMIT;
                default:  dec.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
    parameter int N_REG = 13,
    parameter int REG_W = 8,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [REG_W-1:0]             wr_data,
    output logic [N_REG-1:0][REG_W-1:0]  cfg_q
);
    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        logic [REG_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= wr_data;
        end
        assign cfg_q[g] = q;
    end
endmodule

// File: rtl/gpio_pin_data.sv
module gpio_pin_data #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] data_q,
    output logic [W-1:0] pin_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                data_q[i] <= 1'b0;
            else if (!dir[i])
                data_q[i] <= pin_i[i];
            else if (wr_en && wr_mask[i])
                data_q[i] <= wr_data[i];
        end
        assign pin_o[i] = dir[i] ? data_q[i] : 1'b1;
    end
endmodule

// File: rtl/gpio_alt_guard.sv
module gpio_alt_guard #(
    parameter int W     = 8,
    parameter int BUS_W = 32,
    parameter logic [BUS_W-1:0] KEY = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_wr,
    input  logic             commit_wr,
    input  logic             alt_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             locked_q,
    output logic [W-1:0]     commit_q,
    output logic [W-1:0]     afsel_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
            commit_q <= '1;
            afsel_q  <= '0;
        end else begin
            if (lock_wr)
                locked_q <= (wdata != KEY);
            if (commit_wr && !locked_q)
                commit_q <= wdata[W-1:0];
            if (alt_wr)
                afsel_q <= (afsel_q & ~commit_q) | (wdata[W-1:0] & commit_q);
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_i,
    output logic [PIN_W-1:0]  pin_o,
    output logic [PIN_W-1:0]  afsel_o,
    output logic              irq_o
);
    localparam int CFG_DIR   = 0;
    localparam int CFG_IMASK = 4;

    decode_t                        dec;
    logic [NUM_CFG-1:0][PIN_W-1:0]  cfg_q;
    logic [PIN_W-1:0]               dir_q;
    logic [PIN_W-1:0]               data_q;
    logic                           locked_q;
    logic [PIN_W-1:0]               commit_q;
    logic [PIN_W-1:0]               afsel_q;
    logic [PIN_W-1:0]               raw_q;
    logic [PIN_W-1:0]               masked;

    gpio_addr_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_cfg_bank #(.N_REG(NUM_CFG), .REG_W(PIN_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we && dec.sel == SEL_CFG),
        .wr_idx  (dec.cfg_idx),
        .wr_data (bus_wdata[PIN_W-1:0]),
        .cfg_q   (cfg_q)
    );

    assign dir_q = cfg_q[CFG_DIR];

    gpio_pin_data #(.W(PIN_W)) u_data (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we && dec.sel == SEL_DATA),
        .wr_mask (dec.pin_mask),
        .wr_data (bus_wdata[PIN_W-1:0]),
        .dir     (dir_q),
        .pin_i   (pin_i),
        .data_q  (data_q),
        .pin_o   (pin_o)
    );

    gpio_alt_guard #(.W(PIN_W), .BUS_W(BUS_W), .KEY(UNLOCK_KEY)) u_alt (
        .clk       (clk),
        .rst       (rst),
        .lock_wr   (bus_we && dec.sel == SEL_LOCK),
        .commit_wr (bus_we && dec.sel == SEL_COMMIT),
        .alt_wr    (bus_we && dec.sel == SEL_ALT),
        .wdata     (bus_wdata),
        .locked_q  (locked_q),
        .commit_q  (commit_q),
        .afsel_q   (afsel_q)
    );

    // Raw status: storage with write-one-to-clear; no detection source sets it.
    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= '0;
        else if (bus_we && dec.sel == SEL_ICLR)
            raw_q <= raw_q & ~bus_wdata[PIN_W-1:0];
    end

    assign masked  = raw_q & cfg_q[CFG_IMASK];
    assign irq_o   = |masked;
    assign afsel_o = afsel_q;

    always_comb begin
        case (dec.sel)
            SEL_DATA:   bus_rdata = BUS_W'(data_q & dec.pin_mask);
            SEL_CFG:    bus_rdata = BUS_W'(cfg_q[dec.cfg_idx]);
            SEL_RAW:    bus_rdata = BUS_W'(raw_q);
            SEL_MASKED: bus_rdata = BUS_W'(masked);
            SEL_ALT:    bus_rdata = BUS_W'(afsel_q);
            SEL_LOCK:   bus_rdata = BUS_W'(locked_q);
            SEL_COMMIT: bus_rdata = BUS_W'(commit_q);
            SEL_ID:     bus_rdata = BUS_W'(id_byte(dec.id_idx));
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  pin_i,
    input logic [PIN_W-1:0]  dir_q,
    input logic [PIN_W-1:0]  data_q,
    input logic              locked_q,
    input logic [PIN_W-1:0]  commit_q,
    input logic [PIN_W-1:0]  afsel_q
);
    logic data_wr, lock_wr, commit_wr;
    assign data_wr   = bus_we && bus_addr[ADDR_W-1:2] < W_DATA_END;
    assign lock_wr   = bus_we && bus_addr[ADDR_W-1:2] == W_LOCK;
    assign commit_wr = bus_we && bus_addr[ADDR_W-1:2] == W_COMMIT;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (locked_q && commit_q == '1 && afsel_q == '0 && dir_q == '0));

    assert_masked_write_R3: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (((data_q ^ $past(data_q)) & $past(dir_q)
                      & ~$past(bus_addr[PIN_W+1:2])) == '0));

    assert_input_follow_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((data_q ^ $past(pin_i)) & ~$past(dir_q)) == '0));

    assert_key_unlocks_R6: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && bus_wdata == UNLOCK_KEY) |=> !locked_q);

    assert_other_locks_R6: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && bus_wdata != UNLOCK_KEY) |=> locked_q);

    assert_commit_guard_R7: assert property (@(posedge clk) disable iff (rst)
        (commit_wr && locked_q) |=> $stable(commit_q));

    assert_alt_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((afsel_q ^ $past(afsel_q)) & ~$past(commit_q)) == '0));
endmodule

bind gpio_port gpio_port_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_i     (pin_i),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .locked_q  (locked_q),
    .commit_q  (commit_q),
    .afsel_q   (afsel_q)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_i = '0;
    logic [7:0]  pin_o;
    logic [7:0]  afsel_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_i     (pin_i),
        .pin_o     (pin_o),
        .afsel_o   (afsel_o),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  d;
        logic [7:0]  idv [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                                  8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        #1 chk("R1 pin_o", {24'h0, pin_o}, 32'hFF);
        chk("R1 afsel_o", {24'h0, afsel_o}, 32'h0);
        chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
        rd(12'h400, r); chk("R1 dir", r, 32'h0);
        rd(12'h520, r); chk("R1 lock", r, 32'h1);
        rd(12'h524, r); chk("R1 commit", r, 32'hFF);
        rd(12'h420, r); chk("R1 afsel", r, 32'h0);

        // R10: identification words
        for (int k = 0; k < 12; k++) begin
            rd(12'hFD0 + 12'(4 * k), r);
            chk("R10 id", r, {24'h0, idv[k]});
        end

        // R9: byte registers store low byte, upper bits read 0
        for (int k = 0; k < 13; k++) begin
            logic [11:0] off;
            logic [7:0]  pat;
            off = (k < 5) ? 12'h400 + 12'(4 * k) : 12'h500 + 12'(4 * (k - 5));
            pat = 8'h5A ^ 8'(k * 8'h13);
            wr(off, {24'hFFFFFF, pat});
            rd(off, r);
            chk("R9 cfg readback", r, {24'h0, pat});
        end
        wr(12'h400, 32'h0);

        // R5 / R4: all inputs, data follows pins, pins float high
        for (int p = 0; p < 256; p++) begin
            @(negedge clk); pin_i = 8'(p);
            rd(12'h3FC, r);
            chk("R5 input follow", r, 32'(p));
            chk("R4 float high", {24'h0, pin_o}, 32'hFF);
        end

        // R2: every mask against a fixed input pattern
        @(negedge clk); pin_i = 8'h5A;
        for (int m = 0; m < 256; m++) begin
            rd(12'(m << 2), r);
            chk("R2 masked read", r, 32'(8'h5A & 8'(m)));
        end

        // R3 / R4: upper nibble outputs, every mask
        @(negedge clk); pin_i = 8'h3C;
        @(negedge clk);
        wr(12'h400, 32'hF0);
        d = 8'h3C;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] v;
            v = 8'(m * 37) ^ 8'hC3;
            wr(12'(m << 2), {24'hABCDEF, v});
            d = (d & ~(8'(m) & 8'hF0)) | (v & 8'(m) & 8'hF0);
            chk("R4 pin drive", {24'h0, pin_o}, {24'h0, (d & 8'hF0) | 8'h0F});
            rd(12'h3FC, r);
            chk("R3 masked write", r, {24'h0, (d & 8'hF0) | 8'h0C});
        end

        // R5: pin changes on output pins ignored
        @(negedge clk); pin_i = 8'hC3;
        rd(12'h3FC, r);
        chk("R5 output pins ignore input", r, {24'h0, (d & 8'hF0) | 8'h03});

        // R11: no source, masked status and irq stay low whatever the mask
        wr(12'h410, 32'hFF);
        rd(12'h414, r); chk("R11 raw", r, 32'h0);
        rd(12'h418, r); chk("R11 masked", r, 32'h0);
        chk("R11 irq", {31'h0, irq_o}, 32'h0);
        wr(12'h41C, 32'hFF);
        rd(12'h414, r); chk("R11 raw after clear", r, 32'h0);

        // R7 / R8 / R6: lock, commit, alternate select
        wr(12'h524, 32'h0F);
        rd(12'h524, r); chk("R7 commit locked", r, 32'hFF);
        wr(12'h420, 32'hFF);
        rd(12'h420, r); chk("R8 afsel full commit", r, 32'hFF);
        wr(12'h520, 32'h0ACCE550);
        rd(12'h520, r); chk("R6 near key stays locked", r, 32'h1);
        wr(12'h520, 32'h0ACCE551);
        rd(12'h520, r); chk("R6 key unlocks", r, 32'h0);
        wr(12'h524, 32'h0F);
        rd(12'h524, r); chk("R7 commit unlocked", r, 32'h0F);
        wr(12'h520, 32'h12345678);
        rd(12'h520, r); chk("R6 other value locks", r, 32'h1);
        wr(12'h524, 32'h00);
        rd(12'h524, r); chk("R7 commit relocked", r, 32'h0F);
        wr(12'h420, 32'h00);
        rd(12'h420, r); chk("R8 afsel gated", r, 32'hF0);
        chk("R8 afsel_o", {24'h0, afsel_o}, 32'hF0);
        wr(12'h420, 32'h0A);
        rd(12'h420, r); chk("R8 afsel gated set", r, 32'hFA);

        // R12: unmapped reads 0, writes have no effect
        rd(12'h424, r); chk("R12 unmapped 424", r, 32'h0);
        rd(12'h4FC, r); chk("R12 unmapped 4FC", r, 32'h0);
        rd(12'h528, r); chk("R12 unmapped 528", r, 32'h0);
        rd(12'hFCC, r); chk("R12 unmapped FCC", r, 32'h0);
        rd(12'h800, r); chk("R12 unmapped 800", r, 32'h0);
        rd(12'h41C, r); chk("R12 clear write-only", r, 32'h0);
        wr(12'h424, 32'hFFFFFFFF);
        wr(12'h600, 32'hFFFFFFFF);
        wr(12'hFCC, 32'hFFFFFFFF);
        wr(12'h414, 32'hFFFFFFFF);
        rd(12'h400, r); chk("R12 dir kept", r, 32'hF0);
        rd(12'h420, r); chk("R12 afsel kept", r, 32'hFA);
        rd(12'h414, r); chk("R12 raw kept", r, 32'h0);
        rd(12'h524, r); chk("R12 commit kept", r, 32'h0F);
        chk("R12 pins kept", {24'h0, pin_o}, {24'h0, (d & 8'hF0) | 8'h0F});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule